// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block sequences a single-bus processor through its instruction subcycles. It holds the program counter, memory address register, memory buffer register, instruction register, stack pointer and interrupt-enable flag. A state machine steps these registers through their transfers. It also drives read and write strobes toward a synchronous memory port, and each strobe waits on a ready handshake.

Each instruction begins with a fetch. An indirect subcycle follows only when the decoder flags the operand as indirect. Next comes an execute handoff to an external unit through a start/done handshake. If the decoder reports that the opcode writes memory, a write-back follows. The cycle ends with an interrupt subcycle only when a request is pending and interrupts are enabled. The interrupt subcycle pushes the incremented PC onto a descending stack and then redirects fetch to a fixed handler vector.

Top module: `icyc_ctrl`

## Requirements
- R1: While rst_ni is low, no memory strobe is active, ie_o is 0 and pc_o equals RESET_PC. After release, the first memory access is a read at RESET_PC.
- R2: A fetch reads memory at the current PC. The returned word appears on ir_o, and PC advances by one before execute starts.
- R3: A read or write strobe stays asserted, with address and write data unchanged, until mem_ready_i is seen high. Read and write are never active together.
- R4: The operand address field is the low AW bits of a word. When ind_hint_i is low, execute receives the instruction's field on mem_addr_o. When ind_hint_i is high, one extra read occurs at that field, and execute receives the field of the returned word.
- R5: exec_start_o is a single-cycle pulse. No memory access or new fetch happens until exec_done_i is seen high.
- R6: When wr_hint_i is high at completion of execute, exec_data_i is written to the operand address before anything else.
- R7: A taken interrupt decrements the stack pointer (reset value STACK_TOP) and writes the incremented PC at the new stack pointer. The next fetch then reads at INT_VEC.
- R8: Interrupt entry requires irq_i high together with the enable flag. ie_set_i sets the flag, and entry clears it. While the flag is clear, irq_i has no effect and fetch continues at PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory address (MAR) |
| mem_wdata_o | output | DW | Memory write data (MBR) |
| mem_rdata_i | input | DW | Memory read data |
| mem_ready_i | input | 1 | Access completes this cycle |
| ind_hint_i | input | 1 | Decoded: operand is indirect |
| wr_hint_i | input | 1 | Decoded: opcode writes memory |
| irq_i | input | 1 | Interrupt request |
| ie_set_i | input | 1 | Set interrupt-enable flag |
| ie_o | output | 1 | Interrupt-enable flag |
| exec_start_o | output | 1 | Execute start pulse |
| exec_done_i | input | 1 | Execute finished |
| exec_data_i | input | DW | Result to store on write-back |
| ir_o | output | DW | Instruction register |
| pc_o | output | AW | Program counter |

## Verification
The bench runs several instruction patterns and checks the full ordered trace of memory accesses and execute handoffs. The patterns are direct, indirect, write-back, and indirect combined with write-back. Together they show whether the extra indirect read and the write-back happen only when flagged, and that each is aimed at the right address. Ready latencies of zero, one, two and three cycles show that strobes really wait and are not tied to a fixed delay.

Interrupt cases cover three situations: the flag clear, the flag set once, and the flag set again after the handler. These confirm gating, clearing on entry, and stack decrement across two pushes. A final case combines a write-back with an interrupt to show that the write-back comes before the push.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  typedef enum logic [3:0] {
    S_FETCH_ADDR,
    S_FETCH_RD,
    S_FETCH_IR,
    S_DECODE,
    S_IND_ADDR,
    S_IND_RD,
    S_EXEC_ADDR,
    S_EXEC_GO,
    S_EXEC_WAIT,
    S_WB_LOAD,
    S_WB_WR,
    S_INT_SAVE,
    S_INT_WR,
    S_INT_VEC
  } cyc_state_e;

  typedef struct packed {
    logic pc_to_mar;
    logic mbr_to_mar;
    logic mem_to_mbr;
    logic exe_to_mbr;
    logic pc_to_mbr;
    logic mbr_to_ir;
    logic pc_inc;
    logic sp_push;
    logic ie_clr;
    logic vec_to_pc;
    logic mem_rd;
    logic mem_wr;
    logic exec_start;
  } xfer_ctrl_t;

endpackage

// File: rtl/icyc_fsm.sv
module icyc_fsm
  import icyc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mem_ready_i,
  input  logic       ind_hint_i,
  input  logic       wr_hint_i,
  input  logic       irq_i,
  input  logic       ie_i,
  input  logic       exec_done_i,
  output xfer_ctrl_t ctrl_o
);

  cyc_state_e state_q, state_d;
  logic       int_take;

  assign int_take = irq_i & ie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH_ADDR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o  = '0;
    state_d = state_q;
    case (state_q)
      S_FETCH_ADDR: begin
        ctrl_o.pc_to_mar = 1'b1;
        state_d          = S_FETCH_RD;
      end
      S_FETCH_RD: begin
        ctrl_o.mem_rd = 1'b1;
        if (mem_ready_i) begin
          ctrl_o.mem_to_mbr = 1'b1;
          state_d           = S_FETCH_IR;
        end
      end
      S_FETCH_IR: begin
        ctrl_o.mbr_to_ir = 1'b1;
        ctrl_o.pc_inc    = 1'b1;
        state_d          = S_DECODE;
      end
      // hints are valid once IR holds the new word
      S_DECODE: state_d = ind_hint_i ? S_IND_ADDR : S_EXEC_ADDR;
      S_IND_ADDR: begin
        ctrl_o.mbr_to_mar = 1'b1;
        state_d           = S_IND_RD;
      end
      S_IND_RD: begin
        ctrl_o.mem_rd = 1'b1;
        if (mem_ready_i) begin
          ctrl_o.mem_to_mbr = 1'b1;
          state_d           = S_EXEC_ADDR;
        end
      end
      S_EXEC_ADDR: begin
        ctrl_o.mbr_to_mar = 1'b1;
        state_d           = S_EXEC_GO;
      end
      S_EXEC_GO: begin
        ctrl_o.exec_start = 1'b1;
        state_d           = S_EXEC_WAIT;
      end
      S_EXEC_WAIT: begin
        if (exec_done_i) begin
          if (wr_hint_i)     state_d = S_WB_LOAD;
          else if (int_take) state_d = S_INT_SAVE;
          else               state_d = S_FETCH_ADDR;
        end
      end
      S_WB_LOAD: begin
        ctrl_o.exe_to_mbr = 1'b1;
        state_d           = S_WB_WR;
      end
      S_WB_WR: begin
        ctrl_o.mem_wr = 1'b1;
        if (mem_ready_i) state_d = int_take ? S_INT_SAVE : S_FETCH_ADDR;
      end
      S_INT_SAVE: begin
        ctrl_o.pc_to_mbr = 1'b1;
        ctrl_o.sp_push   = 1'b1;
        ctrl_o.ie_clr    = 1'b1;
        state_d          = S_INT_WR;
      end
      S_INT_WR: begin
        ctrl_o.mem_wr = 1'b1;
        if (mem_ready_i) state_d = S_INT_VEC;
      end
      S_INT_VEC: begin
        ctrl_o.vec_to_pc = 1'b1;
        state_d          = S_FETCH_ADDR;
      end
      default: state_d = S_FETCH_ADDR;
    endcase
  end

  p_rw_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o.mem_rd && ctrl_o.mem_wr));

  p_exec_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.exec_start |=> !ctrl_o.exec_start);

  p_exec_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXEC_WAIT && !exec_done_i) |=> (state_q == S_EXEC_WAIT));

  p_int_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_INT_SAVE) |-> $past(irq_i && ie_i));

endmodule

// File: rtl/icyc_dp.sv
module icyc_dp
  import icyc_pkg::*;
#(
  parameter int unsigned     AW        = 8,
  parameter int unsigned     DW        = 16,
  parameter logic [AW-1:0]   RESET_PC  = '0,
  parameter logic [AW-1:0]   STACK_TOP = 8'hF0,
  parameter logic [AW-1:0]   INT_VEC   = 8'h40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  xfer_ctrl_t    ctrl_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic [DW-1:0] exec_data_i,
  input  logic          ie_set_i,
  output logic [AW-1:0] mar_o,
  output logic [DW-1:0] mbr_o,
  output logic [DW-1:0] ir_o,
  output logic [AW-1:0] pc_o,
  output logic          ie_o
);

  logic [AW-1:0] pc_q, mar_q, sp_q, sp_dec;
  logic [DW-1:0] mbr_q, ir_q;
  logic          ie_q;

  assign sp_dec = sp_q - AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= RESET_PC;
    end else if (ctrl_i.vec_to_pc) begin
      pc_q <= INT_VEC;
    end else if (ctrl_i.pc_inc) begin
      pc_q <= pc_q + AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
    end else if (ctrl_i.pc_to_mar) begin
      mar_q <= pc_q;
    end else if (ctrl_i.mbr_to_mar) begin
      mar_q <= mbr_q[AW-1:0];
    end else if (ctrl_i.sp_push) begin
      mar_q <= sp_dec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbr_q <= '0;
    end else if (ctrl_i.mem_to_mbr) begin
      mbr_q <= mem_rdata_i;
    end else if (ctrl_i.exe_to_mbr) begin
      mbr_q <= exec_data_i;
    end else if (ctrl_i.pc_to_mbr) begin
      mbr_q <= DW'(pc_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ir_q <= '0;
    else if (ctrl_i.mbr_to_ir) ir_q <= mbr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sp_q <= STACK_TOP;
    else if (ctrl_i.sp_push) sp_q <= sp_dec;
  end

  // clear on entry wins over a simultaneous set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ie_q <= 1'b0;
    else if (ctrl_i.ie_clr) ie_q <= 1'b0;
    else if (ie_set_i)      ie_q <= 1'b1;
  end

  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;
  assign pc_o  = pc_q;
  assign ie_o  = ie_q;

  p_ie_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.ie_clr |=> !ie_q);

  p_push_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.sp_push |=> (mar_q == sp_q));

endmodule

// File: rtl/icyc_ctrl.sv
module icyc_ctrl
  import icyc_pkg::*;
#(
  parameter int unsigned   AW        = 8,
  parameter int unsigned   DW        = 16,
  parameter logic [AW-1:0] RESET_PC  = '0,
  parameter logic [AW-1:0] STACK_TOP = 8'hF0,
  parameter logic [AW-1:0] INT_VEC   = 8'h40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  input  logic          ind_hint_i,
  input  logic          wr_hint_i,
  input  logic          irq_i,
  input  logic          ie_set_i,
  output logic          ie_o,
  output logic          exec_start_o,
  input  logic          exec_done_i,
  input  logic [DW-1:0] exec_data_i,
  output logic [DW-1:0] ir_o,
  output logic [AW-1:0] pc_o
);

  xfer_ctrl_t ctrl;
  logic       ie;

  icyc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_ready_i(mem_ready_i),
    .ind_hint_i (ind_hint_i),
    .wr_hint_i  (wr_hint_i),
    .irq_i      (irq_i),
    .ie_i       (ie),
    .exec_done_i(exec_done_i),
    .ctrl_o     (ctrl)
  );

  icyc_dp #(
    .AW       (AW),
    .DW       (DW),
    .RESET_PC (RESET_PC),
    .STACK_TOP(STACK_TOP),
    .INT_VEC  (INT_VEC)
  ) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .mem_rdata_i(mem_rdata_i),
    .exec_data_i(exec_data_i),
    .ie_set_i   (ie_set_i),
    .mar_o      (mem_addr_o),
    .mbr_o      (mem_wdata_o),
    .ir_o       (ir_o),
    .pc_o       (pc_o),
    .ie_o       (ie)
  );

  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign exec_start_o = ctrl.exec_start;
  assign ie_o         = ie;

  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_ready_i) |=> (mem_rd_o && $stable(mem_addr_o)));

  p_wr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !mem_ready_i) |=> (mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

endmodule

// File: tb/icyc_ctrl_bench.sv
module icyc_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] STK = 8'hF0;
  localparam logic [AW-1:0] VEC = 8'h40;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mem_rd_o, mem_wr_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          mem_ready_i = 1'b0;
  logic          ind_hint_i, wr_hint_i;
  logic          irq_i = 1'b0;
  logic          ie_set_i = 1'b0;
  logic          ie_o, exec_start_o;
  logic          exec_done_i = 1'b0;
  logic [DW-1:0] exec_data_i = 16'hBEEF;
  logic [DW-1:0] ir_o;
  logic [AW-1:0] pc_o;

  always #4 clk = ~clk;

  icyc_ctrl #(.AW(AW), .DW(DW), .STACK_TOP(STK), .INT_VEC(VEC)) u_icyc_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .ind_hint_i(ind_hint_i), .wr_hint_i(wr_hint_i), .irq_i(irq_i),
    .ie_set_i(ie_set_i), .ie_o(ie_o), .exec_start_o(exec_start_o),
    .exec_done_i(exec_done_i), .exec_data_i(exec_data_i), .ir_o(ir_o), .pc_o(pc_o)
  );

  // bench decoder: bit15 indirect, bit14 writes memory, bit13 enables interrupts
  assign ind_hint_i = ir_o[15];
  assign wr_hint_i  = ir_o[14];

  logic [DW-1:0] prog [256];
  int lat = 0;
  int exec_lat = 1;

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;

  // memory responder and access log
  int            n_log;
  logic          log_wr   [32];
  logic [AW-1:0] log_addr [32];
  logic [DW-1:0] log_data [32];
  logic          acc_busy, acc_wr;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_data;
  int            held;

  always @(negedge clk) begin
    if (!rst_ni) begin
      n_log = 0; acc_busy = 0; held = 0; mem_ready_i = 0;
      if (mem_rd_o || mem_wr_o) begin
        mon_chk++; mon_fail++;
        $display("FAIL R1 strobe during reset: rd=%0b wr=%0b expected 0", mem_rd_o, mem_wr_o);
      end
    end else begin
      mem_ready_i = 0;
      if (mem_rd_o && mem_wr_o) begin
        mon_chk++; mon_fail++;
        $display("FAIL R3 read and write together: actual 1 expected 0");
      end
      if (mem_rd_o || mem_wr_o) begin
        if (!acc_busy) begin
          acc_busy = 1; acc_addr = mem_addr_o; acc_data = mem_wdata_o;
          acc_wr = mem_wr_o; held = 0;
        end else if (mem_addr_o != acc_addr || mem_wr_o != acc_wr ||
                     (acc_wr && mem_wdata_o != acc_data)) begin
          mon_chk++; mon_fail++;
          $display("FAIL R3 access changed while waiting: addr %h expected %h", mem_addr_o, acc_addr);
        end
        held++;
        if (held == lat + 1) begin
          mem_ready_i = 1;
          mem_rdata_i = prog[mem_addr_o];
          if (n_log < 32) begin
            log_wr[n_log]   = mem_wr_o;
            log_addr[n_log] = mem_addr_o;
            log_data[n_log] = mem_wr_o ? mem_wdata_o : prog[mem_addr_o];
          end
          n_log++;
          mon_chk++;
          acc_busy = 0;
        end
      end else if (acc_busy) begin
        mon_chk++; mon_fail++;
        $display("FAIL R3 strobe dropped after %0d cycles, expected %0d", held, lat + 1);
        acc_busy = 0;
      end
    end
  end

  // execute unit model
  int            n_exe;
  logic [AW-1:0] exe_addr [32];
  logic [DW-1:0] exe_ir   [32];
  logic [AW-1:0] exe_pc   [32];
  logic          ebusy;
  int            ecnt;

  always @(negedge clk) begin
    if (!rst_ni) begin
      n_exe = 0; ebusy = 0; ecnt = 0; exec_done_i = 0; ie_set_i = 0;
    end else begin
      exec_done_i = 0; ie_set_i = 0;
      if (exec_start_o) begin
        if (ebusy) begin
          mon_chk++; mon_fail++;
          $display("FAIL R5 exec_start_o held or repeated: actual 1 expected 0");
        end
        ebusy = 1; ecnt = 0;
        if (n_exe < 32) begin
          exe_addr[n_exe] = mem_addr_o; exe_ir[n_exe] = ir_o; exe_pc[n_exe] = pc_o;
        end
        n_exe++;
        ie_set_i = ir_o[13];
      end else if (ebusy) begin
        if (mem_rd_o || mem_wr_o) begin
          mon_chk++; mon_fail++;
          $display("FAIL R5 memory strobe during execute: actual 1 expected 0");
        end
        ecnt++;
        if (ecnt == exec_lat) begin exec_done_i = 1; ebusy = 0; end
      end
    end
  end

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      $display("FAIL watchdog expired: actual %0d cycles expected < 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = '0;
  endtask

  task automatic start(input int l, input int el, input logic irq);
    lat = l; exec_lat = el; irq_i = irq;
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic wait_acc(input int n);
    while (n_log < n) @(posedge clk);
    #1;
  endtask

  task automatic exp_acc(input int i, input bit wr, input int addr, input int data, input string req);
    if (i >= n_log) begin
      chk(0, req, "missing access", n_log, i + 1);
    end else begin
      chk(log_wr[i] == wr, req, $sformatf("access %0d kind", i), int'(log_wr[i]), int'(wr));
      chk(log_addr[i] == addr[AW-1:0], req, $sformatf("access %0d addr", i), int'(log_addr[i]), addr);
      chk(log_data[i] == data[DW-1:0], req, $sformatf("access %0d data", i), int'(log_data[i]), data);
    end
  endtask

  task automatic exp_exe(input int i, input int addr, input string req);
    chk(i < n_exe && exe_addr[i] == addr[AW-1:0], req, $sformatf("exec %0d operand addr", i),
        int'(exe_addr[i]), addr);
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = 16'h0012;
    rst_ni = 0; lat = 0; exec_lat = 1; irq_i = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(!mem_rd_o && !mem_wr_o, "R1", "strobes in reset", int'(mem_rd_o | mem_wr_o), 0);
    chk(ie_o == 1'b0, "R1", "ie_o in reset", int'(ie_o), 0);
    chk(pc_o == 8'h00, "R1", "pc_o in reset", int'(pc_o), 0);
    @(negedge clk); rst_ni = 1;
    wait_acc(1);
    exp_acc(0, 0, 16'h00, 16'h0012, "R1");
  endtask

  task automatic t_direct(input int l, input string req);
    clear_prog();
    prog[0] = 16'h0012; prog[1] = 16'h0034;
    start(l, 2, 0);
    wait_acc(3);
    exp_acc(0, 0, 8'h00, 16'h0012, "R2");
    exp_acc(1, 0, 8'h01, 16'h0034, "R2");
    exp_acc(2, 0, 8'h02, 16'h0000, req);
    exp_exe(0, 8'h12, "R4");
    exp_exe(1, 8'h34, "R4");
    chk(exe_ir[0] == 16'h0012, "R2", "ir_o at execute", int'(exe_ir[0]), 16'h0012);
    chk(exe_pc[0] == 8'h01, "R2", "pc_o at execute", int'(exe_pc[0]), 1);
    chk(exe_pc[1] == 8'h02, "R2", "pc_o at second execute", int'(exe_pc[1]), 2);
    chk(n_exe == 2, "R5", "execute count", n_exe, 2);
  endtask

  task automatic t_indirect();
    clear_prog();
    prog[0] = 16'h8020; prog[8'h20] = 16'h0055;
    start(2, 3, 0);
    wait_acc(3);
    exp_acc(0, 0, 8'h00, 16'h8020, "R2");
    exp_acc(1, 0, 8'h20, 16'h0055, "R4");
    exp_acc(2, 0, 8'h01, 16'h0000, "R4");
    exp_exe(0, 8'h55, "R4");
  endtask

  task automatic t_writeback();
    clear_prog();
    prog[0] = 16'h4030;
    start(1, 1, 0);
    wait_acc(3);
    exp_acc(0, 0, 8'h00, 16'h4030, "R2");
    exp_acc(1, 1, 8'h30, 16'hBEEF, "R6");
    exp_acc(2, 0, 8'h01, 16'h0000, "R6");
    exp_exe(0, 8'h30, "R4");
  endtask

  task automatic t_ind_wb();
    clear_prog();
    prog[0] = 16'hC020; prog[8'h20] = 16'h0066;
    start(0, 2, 0);
    wait_acc(4);
    exp_acc(1, 0, 8'h20, 16'h0066, "R4");
    exp_acc(2, 1, 8'h66, 16'hBEEF, "R6");
    exp_acc(3, 0, 8'h01, 16'h0000, "R6");
    exp_exe(0, 8'h66, "R4");
  endtask

  task automatic t_irq_masked();
    clear_prog();
    prog[0] = 16'h0012;
    start(0, 1, 1);
    wait_acc(3);
    exp_acc(1, 0, 8'h01, 16'h0000, "R8");
    exp_acc(2, 0, 8'h02, 16'h0000, "R8");
    chk(ie_o == 1'b0, "R8", "ie_o without set", int'(ie_o), 0);
  endtask

  task automatic t_irq_taken();
    clear_prog();
    prog[0] = 16'h2012; prog[8'h40] = 16'h0000; prog[8'h41] = 16'h2000;
    start(1, 1, 1);
    wait_acc(6);
    exp_acc(0, 0, 8'h00, 16'h2012, "R7");
    exp_acc(1, 1, 8'hEF, 16'h0001, "R7");
    exp_acc(2, 0, 8'h40, 16'h0000, "R7");
    exp_acc(3, 0, 8'h41, 16'h2000, "R8");
    exp_acc(4, 1, 8'hEE, 16'h0042, "R7");
    exp_acc(5, 0, 8'h40, 16'h0000, "R8");
    chk(ie_o == 1'b0, "R8", "ie_o after entry", int'(ie_o), 0);
  endtask

  task automatic t_wb_then_irq();
    clear_prog();
    prog[0] = 16'h6030;
    start(0, 1, 1);
    wait_acc(4);
    exp_acc(1, 1, 8'h30, 16'hBEEF, "R6");
    exp_acc(2, 1, 8'hEF, 16'h0001, "R7");
    exp_acc(3, 0, 8'h40, 16'h0000, "R7");
  endtask

  initial begin
    t_reset();
    t_direct(0, "R2");
    t_direct(3, "R3");
    t_indirect();
    t_writeback();
    t_ind_wb();
    t_irq_masked();
    t_irq_taken();
    t_wb_then_irq();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end

endmodule